// File: doc/BRIEF.md
# Top-Three AC Coefficient Watermark Inserter

This block takes one 8x8 image block as a stream of transform coefficients, keeps the whole block in local storage and finds the AC coefficients of greatest magnitude. The first coefficient of a block is the DC term and never takes part. When the block is complete, the block sends every coefficient back in arrival order. The chosen positions carry an invisible watermark. Each of them is shifted by a pseudo-random amount that scales with its own magnitude and with a strength value.

A producer pushes coefficients through a valid/ready handshake and flags the final beat of a block. The strength value is captured together with that final beat. Software can reseed the internal pseudo-random source between blocks so that the mark can be reproduced. While a block is being sent out, no new input is accepted.

Top module: `ac_mark_inserter`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_last is 0.
- R2: A beat is taken when in_valid and in_ready are both 1. A block closes on the beat that carries in_last, or on its 64th beat if in_last has not come. Beat 0 of every block is the DC term.
- R3: in_ready is 0 from the cycle after a block closes until the cycle after its final output beat. Output beats come one per cycle in input order, and the first arrives two clock edges after the closing beat is taken. out_last is 1 only on the final beat.
- R4: The marked positions are the three beats with index 1 or higher that have the largest absolute value. On equal magnitude the lower index wins. Beat 0 is never marked.
- R5: A marked coefficient c (12-bit two's complement) is output as c + floor(alpha * |c| * w / 256), clamped to the range -2048..2047. Here alpha is unsigned 8-bit and w is signed 8-bit. With alpha equal to 0 the output equals the input.
- R6: w is the low 8 bits of a 16-bit shift register, read as two's complement. The register shifts left and feeds back bit15^bit13^bit12^bit10 into bit 0. After reset it holds 0xACE1. It advances exactly once per marked coefficient, in output order, and keeps its state from block to block.
- R7: A seed_load pulse loads seed into the shift register. A seed of 0 loads 0xACE1 instead.
- R8: alpha is sampled on the closing beat of a block. Changes to alpha while that block is being output have no effect on it.
- R9: A block with fewer than three AC beats marks every AC beat it has. A one-beat block passes through unchanged.
- R10: Every unmarked coefficient is output bit-for-bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input coefficient valid |
| in_ready | output | 1 | Block can take a coefficient |
| in_coef | input | 12 | Signed input coefficient |
| in_last | input | 1 | Final beat of the block |
| alpha | input | 8 | Unsigned embedding strength |
| seed_load | input | 1 | Load pulse for the random source |
| seed | input | 16 | Seed value |
| out_valid | output | 1 | Output coefficient valid |
| out_coef | output | 12 | Signed output coefficient |
| out_last | output | 1 | Final output beat of the block |

## Verification
The bench builds the block with its default parameters: a 64-entry block store and three marked positions. These defaults make a full 64-beat block that closes without in_last possible, along with blocks of one and three beats and ties among many equal magnitudes. Full-scale coefficients at the greatest strength drive the clamp at both ends. Because the random state carries over between blocks, the bench models it across the whole run, including zero and non-zero reseeds.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int CW = 12;
  localparam int WW = 8;
  localparam int AW = 8;
  localparam int LW = 16;
  localparam logic [LW-1:0] LFSR_INIT = 16'hACE1;
  localparam int CMAX = (1 << (CW - 1)) - 1;
  localparam int CMIN = -(1 << (CW - 1));

  typedef enum logic {ST_IN = 1'b0, ST_OUT = 1'b1} phase_e;

  function automatic logic [CW-1:0] coef_mag(input logic [CW-1:0] c);
    return c[CW-1] ? (~c + 1'b1) : c;
  endfunction

  function automatic logic [LW-1:0] lfsr_next(input logic [LW-1:0] s);
    return {s[LW-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [CW-1:0] mark_coef(input logic [CW-1:0] c,
                                              input logic [AW-1:0] a,
                                              input logic [WW-1:0] w);
    int ci, mi, ai, wi, prod, sum;
    ci   = int'($signed(c));
    mi   = int'(coef_mag(c));
    ai   = int'(a);
    wi   = int'($signed(w));
    prod = (ai * mi * wi) >>> 8;
    sum  = ci + prod;
    if (sum > CMAX) sum = CMAX;
    if (sum < CMIN) sum = CMIN;
    return sum[CW-1:0];
  endfunction
endpackage

// File: rtl/acm_lfsr.sv
module acm_lfsr import acm_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] seed,
  input  logic          adv,
  output logic [LW-1:0] state
);
  logic [LW-1:0] seed_eff;
  assign seed_eff = (seed == '0) ? LFSR_INIT : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= LFSR_INIT;
    else if (load) state <= seed_eff;
    else if (adv)  state <= lfsr_next(state);
  end

  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  p_lfsr_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> state != $past(state));
  p_seed_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state == (($past(seed) == '0) ? LFSR_INIT : $past(seed)));
endmodule

// File: rtl/acm_rank.sv
module acm_rank import acm_pkg::*; #(
  parameter int N_MARK = 3,
  parameter int IW     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       cand_vld,
  input  logic [CW-1:0]              cand_mag,
  input  logic [IW-1:0]              cand_idx,
  output logic [N_MARK-1:0]          sel_vld,
  output logic [N_MARK-1:0][IW-1:0]  sel_idx
);
  logic [N_MARK-1:0][CW-1:0] sel_mag;
  logic [N_MARK-1:0]         beats;

  for (genvar k = 0; k < N_MARK; k++) begin : g_slot
    assign beats[k] = !sel_vld[k] || (cand_mag > sel_mag[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_vld[k] <= 1'b0;
        sel_mag[k] <= '0;
        sel_idx[k] <= '0;
      end else if (clr) begin
        sel_vld[k] <= 1'b0;
      end else if (cand_vld && beats[k]) begin
        if (k == 0) begin
          sel_vld[k] <= 1'b1;
          sel_mag[k] <= cand_mag;
          sel_idx[k] <= cand_idx;
        end else if (!beats[(k == 0) ? 0 : k-1]) begin
          sel_vld[k] <= 1'b1;
          sel_mag[k] <= cand_mag;
          sel_idx[k] <= cand_idx;
        end else begin
          sel_vld[k] <= sel_vld[(k == 0) ? 0 : k-1];
          sel_mag[k] <= sel_mag[(k == 0) ? 0 : k-1];
          sel_idx[k] <= sel_idx[(k == 0) ? 0 : k-1];
        end
      end
    end

    p_no_dc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld[k] |-> sel_idx[k] != '0);

    if (k > 0) begin : g_order
      p_sorted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld[k] |-> (sel_vld[k-1] && sel_mag[k-1] >= sel_mag[k]));
      p_tie_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld[k] && sel_mag[k-1] == sel_mag[k]) |-> sel_idx[k-1] < sel_idx[k]);
    end
  end
endmodule

// File: rtl/acm_embed.sv
module acm_embed import acm_pkg::*; (
  input  logic          en,
  input  logic [CW-1:0] coef,
  input  logic [AW-1:0] strength,
  input  logic [WW-1:0] w,
  output logic [CW-1:0] res
);
  logic [CW-1:0] marked;
  assign marked = mark_coef(coef, strength, w);
  assign res    = en ? marked : coef;
endmodule

// File: rtl/ac_mark_inserter.sv
module ac_mark_inserter import acm_pkg::*; #(
  parameter int N_COEF = 64,
  parameter int N_MARK = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_coef,
  input  logic          in_last,
  input  logic [AW-1:0] alpha,
  input  logic          seed_load,
  input  logic [LW-1:0] seed,
  output logic          out_valid,
  output logic [CW-1:0] out_coef,
  output logic          out_last
);
  localparam int IW = $clog2(N_COEF);
  localparam int MCW = $clog2(N_MARK + 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_COEF - 1);

  phase_e        phase_q;
  logic [IW-1:0] wr_idx, rd_idx, end_idx;
  logic [AW-1:0] alpha_q;
  logic [CW-1:0] coef_mem [N_COEF];
  logic [LW-1:0] lfsr_q;

  logic          accept, blk_end, rd_final, hit, mark_evt;
  logic [CW-1:0] rd_coef, emb_coef;
  logic [N_MARK-1:0]         sel_vld, hit_vec;
  logic [N_MARK-1:0][IW-1:0] sel_idx;

  assign in_ready = (phase_q == ST_IN);
  assign accept   = in_valid && in_ready;
  assign blk_end  = accept && (in_last || wr_idx == LAST_IDX);
  assign rd_final = (rd_idx == end_idx);
  assign rd_coef  = coef_mem[rd_idx];

  for (genvar k = 0; k < N_MARK; k++) begin : g_hit
    assign hit_vec[k] = sel_vld[k] && (sel_idx[k] == rd_idx);
  end
  assign hit      = |hit_vec;
  assign mark_evt = (phase_q == ST_OUT) && hit;

  acm_rank #(.N_MARK(N_MARK), .IW(IW)) u_rank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept && wr_idx == '0),
    .cand_vld (accept && wr_idx != '0),
    .cand_mag (coef_mag(in_coef)),
    .cand_idx (wr_idx),
    .sel_vld  (sel_vld),
    .sel_idx  (sel_idx)
  );

  acm_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load),
    .seed  (seed),
    .adv   (mark_evt),
    .state (lfsr_q)
  );

  acm_embed u_embed (
    .en       (hit),
    .coef     (rd_coef),
    .strength (alpha_q),
    .w        (lfsr_q[WW-1:0]),
    .res      (emb_coef)
  );

  always_ff @(posedge clk) begin
    if (accept) coef_mem[wr_idx] <= in_coef;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= ST_IN;
      wr_idx    <= '0;
      rd_idx    <= '0;
      end_idx   <= '0;
      alpha_q   <= '0;
      out_valid <= 1'b0;
      out_coef  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (phase_q == ST_IN) begin
        if (blk_end) begin
          end_idx <= wr_idx;
          alpha_q <= alpha;
          wr_idx  <= '0;
          rd_idx  <= '0;
          phase_q <= ST_OUT;
        end else if (accept) begin
          wr_idx <= wr_idx + 1'b1;
        end
      end else begin
        out_valid <= 1'b1;
        out_coef  <= emb_coef;
        out_last  <= rd_final;
        rd_idx    <= rd_idx + 1'b1;
        if (rd_final) phase_q <= ST_IN;
      end
    end
  end

  logic [MCW-1:0] mark_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mark_cnt <= '0;
    else if (blk_end)  mark_cnt <= '0;
    else if (mark_evt) mark_cnt <= mark_cnt + 1'b1;
  end

  p_mark_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_cnt <= MCW'(N_MARK));
  p_no_take_while_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);
  p_last_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  p_alpha_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_OUT && !rd_final) |=> $stable(alpha_q));
  p_zero_strength_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_OUT && alpha_q == '0) |=> out_coef == $past(rd_coef));
endmodule

// File: tb/ac_mark_inserter_bench.sv
module ac_mark_inserter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, seed_load = 1'b0;
  logic [11:0] in_coef = '0;
  logic [7:0]  alpha = '0;
  logic [15:0] seed = '0;
  logic        in_ready, out_valid, out_last;
  logic [11:0] out_coef;

  int n_tests = 0, n_fail = 0;
  int blk [64];
  int expv [64];
  bit markd [64];
  logic [15:0] m_lfsr;

  always #2.5 clk = ~clk;

  ac_mark_inserter u_ac_mark_inserter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_last(in_last), .alpha(alpha),
    .seed_load(seed_load), .seed(seed), .out_valid(out_valid),
    .out_coef(out_coef), .out_last(out_last));

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int floor256(input int p);
    if (p >= 0) return p / 256;
    return -((-p + 255) / 256);
  endfunction

  function automatic logic [15:0] m_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

  task automatic build_expect(input int n, input int a);
    for (int i = 0; i < n; i++) begin
      int better = 0;
      if (i > 0)
        for (int j = 1; j < n; j++)
          if (j != i && (iabs(blk[j]) > iabs(blk[i]) ||
                         (iabs(blk[j]) == iabs(blk[i]) && j < i))) better++;
      markd[i] = (i > 0) && (better < 3);
    end
    for (int i = 0; i < n; i++) begin
      if (markd[i]) begin
        int w, v;
        w = int'($signed(m_lfsr[7:0]));
        v = blk[i] + floor256(a * iabs(blk[i]) * w);
        if (v > 2047) v = 2047;
        if (v < -2048) v = -2048;
        expv[i] = v;
        m_lfsr = m_step(m_lfsr);
      end else begin
        expv[i] = blk[i];
      end
    end
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk);
    seed_load = 1'b1; seed = s;
    @(negedge clk);
    seed_load = 1'b0;
    m_lfsr = (s == 16'h0) ? 16'hACE1 : s;
  endtask

  task automatic run_block(input int n, input bit use_last, input int a,
                           input int a_late, input string name);
    build_expect(n, a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_coef  = blk[i][11:0];
      in_last  = use_last && (i == n - 1);
      alpha    = a[7:0];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    alpha = a_late[7:0];
    chk(in_ready == 1'b0, use_last ? "R3 ready low after close" : "R2 close at 64th beat",
        int'(in_ready), 0);
    chk(out_valid == 1'b0, "R3 no output on closing+1", int'(out_valid), 0);
    for (int g = 0; g < n; g++) begin
      int wt = 0;
      while (!out_valid && wt < 20) begin @(negedge clk); wt++; end
      if (markd[g])
        chk(int'($signed(out_coef)) == expv[g], {name, " R5,R6 marked coef"},
            int'($signed(out_coef)), expv[g]);
      else
        chk(int'($signed(out_coef)) == expv[g], {name, " R10 passthrough"},
            int'($signed(out_coef)), expv[g]);
      chk(out_last == (g == n - 1), {name, " R3 out_last"}, int'(out_last), int'(g == n - 1));
      if (g < n - 1)
        chk(in_ready == 1'b0, {name, " R3 ready low during output"}, int'(in_ready), 0);
      @(negedge clk);
    end
    chk(out_valid == 1'b0 && in_ready == 1'b1, {name, " R3 idle after block"},
        int'({out_valid, in_ready}), 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 64; i++) blk[i] = ((i * 37) % 200) - 100;
    blk[0] = 2000; blk[5] = 900; blk[20] = -1000; blk[40] = 700; blk[41] = -699;
    run_block(64, 1'b1, 64, 64, "basic R4");
  endtask

  task automatic t_ties();
    for (int i = 0; i < 64; i++) blk[i] = (i % 2) ? -50 : 50;
    blk[0] = 0;
    run_block(64, 1'b1, 200, 200, "ties R4");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 64; i++) blk[i] = (i % 2) ? -2048 : 2047;
    run_block(64, 1'b1, 255, 255, "sat R5");
    for (int i = 0; i < 64; i++) blk[i] = (i % 3 == 0) ? 2047 : -2048;
    run_block(64, 1'b1, 255, 255, "sat2 R5");
  endtask

  task automatic t_seed();
    load_seed(16'h0000);
    for (int i = 0; i < 64; i++) blk[i] = (i * 13) - 400;
    run_block(64, 1'b1, 120, 120, "seed0 R7");
    load_seed(16'h1234);
    run_block(64, 1'b1, 120, 120, "seed R7");
  endtask

  task automatic t_alpha_late();
    for (int i = 0; i < 64; i++) blk[i] = 300 - i * 9;
    run_block(64, 1'b1, 180, 0, "late alpha R8");
  endtask

  task automatic t_alpha_zero();
    for (int i = 0; i < 64; i++) blk[i] = 1500 - i * 40;
    run_block(64, 1'b1, 0, 0, "alpha0 R5");
  endtask

  task automatic t_short();
    blk[0] = -300; blk[1] = 1000; blk[2] = -1200;
    run_block(3, 1'b1, 90, 90, "short R9");
    blk[0] = 777;
    run_block(1, 1'b1, 255, 255, "dc only R9");
  endtask

  task automatic t_no_last();
    for (int i = 0; i < 64; i++) blk[i] = (i * 71) % 500 - 250;
    run_block(64, 1'b0, 100, 100, "nolast R2");
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", c_dummy(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int c_dummy();
    return 1;
  endfunction

  initial begin
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ties();
    t_saturate();
    t_seed();
    t_alpha_late();
    t_alpha_zero();
    t_short();
    t_no_last();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule